// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

An eight-line interrupt controller with a byte-wide register port. A single address bit selects one of two ports. One is the command port, which carries initialization starts and operation commands. The other is the data port, which carries the remaining initialization words and, in normal operation, the mask. The controller keeps three registers: pending requests, lines in service, and the mask. Request inputs are edge sensitive. Priority is fixed, and line 0 ranks highest.

A processor takes an interrupt in two acknowledge pulses:

- The first pulse picks the winning line and moves it from pending to in service.
- The second pulse returns an 8-bit vector. The upper five bits come from the programmed base, and the lower three bits are the line number.

Lines are released in one of two ways. In normal mode, the processor writes a specific end-of-interrupt command. In automatic mode, the second pulse releases the line.

Two instances can be chained as a master and a slave. On a master, a line that has a slave attached drives the line number onto the cascade outputs between the two pulses, and the master returns no vector. A slave answers an acknowledge only when the cascade inputs carry its own identity.

Top module: `pic8_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF, int_req, vec_valid and cas_drive are low, pending and in-service registers are zero, and command-port reads return the pending register.
- R2: A command-port write with bit 4 set restarts programming. It clears pending, in-service, auto-EOI, the slave map and the read select. The next data-port write sets the vector base from bits 7:3. A third data word follows unless bit 1 of the start word was 1 (single mode). A fourth word follows only if bit 0 was 1, and its bit 1 selects auto-EOI. The mask is left unchanged.
- R3: Once programming is complete, a data-port write loads the mask, and a 1 blocks the line. A data-port read returns the mask.
- R4: A rising input sets its pending bit. The bit clears when the input is low, or when the first acknowledge pulse takes the line.
- R5: int_req is registered. It goes high one cycle after the lowest-numbered unmasked pending line ranks strictly above every in-service line.
- R6: The first acknowledge pulse moves the winning line into service. The second pulse makes vec_valid high for one cycle with vec_out = {base[7:3], line}.
- R7: If no line is eligible at the first pulse, the second pulse returns {base[7:3], 3'd7}, sets no in-service bit, and does so even when line 7 is masked.
- R8: A command-port write of 0x60+n (bits 7:5 = 011, bits 4:3 = 00) clears in-service bit n only.
- R9: In auto-EOI mode, the second pulse clears the in-service bit of the acknowledged line.
- R10: A command-port write of 0x0B selects the in-service register for command-port reads, and 0x0A selects the pending register. Read data appears on the cycle after bus_rd.
- R11: On a master, the third word is a bitmap of lines that have slaves. For such a line, the first pulse sets cas_drive and drives cas_out to the line number until the second pulse. The master then gives no vec_valid.
- R12: With slave_mode high, bits 2:0 of the third word are the identity. Acknowledge pulses are ignored unless cas_in equals the identity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slave_mode | input | 1 | 1 = this instance is a slave |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_a0 | input | 1 | 0 = command port, 1 = data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_in | input | 8 | Edge-sensitive request lines |
| int_req | output | 1 | Interrupt request to the processor |
| int_ack | input | 1 | Acknowledge pulse, one cycle each |
| cas_in | input | 3 | Cascade identity seen by a slave |
| cas_out | output | 3 | Cascade line number driven by a master |
| cas_drive | output | 1 | Cascade outputs valid |
| vec_out | output | 8 | Vector byte |
| vec_valid | output | 1 | One-cycle vector strobe |

## Verification
Two conflicts are provoked. In the first, a specific end-of-interrupt for an older in-service line is written in the same cycle as the first acknowledge pulse of a newer, higher-priority line. The selection must use the state before the write, and the in-service register must end up holding only the new line. In the second, a request line drops in the cycle before acknowledge, which must turn the acknowledge into the spurious vector. A behavioural model in the bench computes the pending, in-service and mask state every cycle. It compares the request, vector and cascade outputs on every clock, and checks read-back values against the same model.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int PIC_LINES = 8;
  localparam int PIC_IDW   = $clog2(PIC_LINES);

  typedef enum logic [1:0] {
    ST_WORD2,
    ST_WORD3,
    ST_WORD4,
    ST_RUN
  } init_st_e;

  typedef struct packed {
    logic [7-PIC_IDW:0]   base_hi;
    logic                 aeoi;
    logic [PIC_LINES-1:0] cas_byte;
  } pic_cfg_t;
endpackage

// File: rtl/pic_prio_pick.sv
module pic_prio_pick #(
  parameter int N = 8,
  localparam int IDW = $clog2(N)
) (
  input  logic [N-1:0]   req,
  output logic           any,
  output logic [IDW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDW'(i);
      end
    end
  end
endmodule

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
  import pic_pkg::*;
#(
  parameter int W = PIC_LINES,
  localparam int IDW = $clog2(W)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic           bus_a0,
  input  logic [W-1:0]   bus_wdata,
  input  logic [W-1:0]   irr,
  input  logic [W-1:0]   isr,
  output logic [W-1:0]   mask,
  output pic_cfg_t       cfg,
  output logic [W-1:0]   rdata,
  output logic           init_stb,
  output logic           eoi_stb,
  output logic [IDW-1:0] eoi_idx
);
  init_st_e st_q;
  logic     need3_q, need4_q, rd_isr_q;
  logic     cmd_wr, data_wr, ocw3;

  assign cmd_wr   = bus_wr & ~bus_a0;
  assign data_wr  = bus_wr & bus_a0;
  assign init_stb = cmd_wr & bus_wdata[4];
  assign ocw3     = cmd_wr & ~bus_wdata[4] & bus_wdata[3];
  assign eoi_stb  = cmd_wr & ~bus_wdata[4] & ~bus_wdata[3] & (bus_wdata[7:5] == 3'b011);
  assign eoi_idx  = bus_wdata[IDW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_RUN;
      need3_q  <= 1'b0;
      need4_q  <= 1'b0;
      rd_isr_q <= 1'b0;
      mask     <= '1;
      cfg      <= '0;
      rdata    <= '0;
    end else begin
      if (init_stb) begin
        st_q         <= ST_WORD2;
        need3_q      <= ~bus_wdata[1];
        need4_q      <= bus_wdata[0];
        rd_isr_q     <= 1'b0;
        cfg.aeoi     <= 1'b0;
        cfg.cas_byte <= '0;
      end else if (data_wr) begin
        case (st_q)
          ST_WORD2: begin
            cfg.base_hi <= bus_wdata[7:IDW];
            st_q <= need3_q ? ST_WORD3 : (need4_q ? ST_WORD4 : ST_RUN);
          end
          ST_WORD3: begin
            cfg.cas_byte <= bus_wdata;
            st_q <= need4_q ? ST_WORD4 : ST_RUN;
          end
          ST_WORD4: begin
            cfg.aeoi <= bus_wdata[1];
            st_q <= ST_RUN;
          end
          default: mask <= bus_wdata;
        endcase
      end
      if (ocw3 && bus_wdata[1]) rd_isr_q <= bus_wdata[0];
      if (bus_rd) rdata <= bus_a0 ? mask : (rd_isr_q ? isr : irr);
    end
  end

  a_r2_start_seq: assert property (@(posedge clk) disable iff (rst)
    init_stb |=> (st_q == ST_WORD2));
  a_r3_mask_load: assert property (@(posedge clk) disable iff (rst)
    (data_wr && st_q == ST_RUN) |=> (mask == $past(bus_wdata)));
  a_r10_sel_isr: assert property (@(posedge clk) disable iff (rst)
    (ocw3 && bus_wdata[1:0] == 2'b11) |=> rd_isr_q);
endmodule

// File: rtl/pic_req_core.sv
module pic_req_core
  import pic_pkg::*;
#(
  parameter int N = PIC_LINES,
  localparam int IDW = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           slave_mode,
  input  logic [N-1:0]   irq_in,
  input  logic [N-1:0]   mask,
  input  pic_cfg_t       cfg,
  input  logic           init_stb,
  input  logic           eoi_stb,
  input  logic [IDW-1:0] eoi_idx,
  input  logic           int_ack,
  input  logic [IDW-1:0] cas_in,
  output logic [N-1:0]   irr_q,
  output logic [N-1:0]   isr_q,
  output logic           int_req,
  output logic [7:0]     vec_out,
  output logic           vec_valid,
  output logic [IDW-1:0] cas_out,
  output logic           cas_drive
);
  localparam logic [IDW-1:0] SPUR_IDX = IDW'(N - 1);

  logic [N-1:0]   irq_q, irr_n, isr_n, pend;
  logic           phase_q, spur_q, casc_q;
  logic [IDW-1:0] sel_q, p_idx, s_idx;
  logic           p_any, s_any, elig, ack_me, ack1, ack2, cascaded;

  assign pend = irr_q & ~mask;

  pic_prio_pick #(.N(N)) u_pend_pick (.req(pend),  .any(p_any), .idx(p_idx));
  pic_prio_pick #(.N(N)) u_srv_pick  (.req(isr_q), .any(s_any), .idx(s_idx));

  assign elig     = p_any && (!s_any || (p_idx < s_idx));
  assign ack_me   = int_ack && (!slave_mode || (cas_in == cfg.cas_byte[IDW-1:0]));
  assign ack1     = ack_me && !phase_q;
  assign ack2     = ack_me && phase_q;
  assign cascaded = !slave_mode && elig && cfg.cas_byte[p_idx];

  for (genvar g = 0; g < N; g++) begin : g_line
    always_comb begin
      irr_n[g] = (irr_q[g] | (irq_in[g] & ~irq_q[g])) & irq_in[g];
      isr_n[g] = isr_q[g];
      if (ack1 && elig && (p_idx == IDW'(g))) begin
        irr_n[g] = 1'b0;
        isr_n[g] = 1'b1;
      end
      if (ack2 && cfg.aeoi && !spur_q && (sel_q == IDW'(g))) isr_n[g] = 1'b0;
      if (eoi_stb && (eoi_idx == IDW'(g))) isr_n[g] = 1'b0;
      if (init_stb) begin
        irr_n[g] = 1'b0;
        isr_n[g] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q     <= '0;
      irr_q     <= '0;
      isr_q     <= '0;
      int_req   <= 1'b0;
      phase_q   <= 1'b0;
      spur_q    <= 1'b0;
      casc_q    <= 1'b0;
      sel_q     <= '0;
      vec_out   <= '0;
      vec_valid <= 1'b0;
      cas_out   <= '0;
      cas_drive <= 1'b0;
    end else begin
      irq_q     <= irq_in;
      irr_q     <= irr_n;
      isr_q     <= isr_n;
      int_req   <= elig;
      vec_valid <= 1'b0;
      if (init_stb) begin
        phase_q   <= 1'b0;
        cas_drive <= 1'b0;
        cas_out   <= '0;
      end else if (ack1) begin
        phase_q   <= 1'b1;
        sel_q     <= elig ? p_idx : SPUR_IDX;
        spur_q    <= !elig;
        casc_q    <= cascaded;
        cas_out   <= cascaded ? p_idx : '0;
        cas_drive <= cascaded;
      end else if (ack2) begin
        phase_q   <= 1'b0;
        vec_valid <= !casc_q;
        vec_out   <= {cfg.base_hi, sel_q};
        cas_drive <= 1'b0;
        cas_out   <= '0;
      end
    end
  end

  a_r4_irr_needs_input: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((irr_q & ~$past(irq_in)) == '0));
  a_r7_spur_no_isr: assert property (@(posedge clk) disable iff (rst)
    (ack1 && !elig && !eoi_stb && !init_stb) |=> (isr_q == $past(isr_q)));
  a_r8_eoi_clears: assert property (@(posedge clk) disable iff (rst)
    eoi_stb |=> !isr_q[$past(eoi_idx)]);
  a_r9_auto_release: assert property (@(posedge clk) disable iff (rst)
    (ack2 && cfg.aeoi && !spur_q) |=> !isr_q[$past(sel_q)]);
  a_r11_cas_window: assert property (@(posedge clk) disable iff (rst)
    cas_drive |-> (phase_q && !slave_mode));
  a_r6_vec_base: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> (vec_out[7:IDW] == $past(cfg.base_hi)));
endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl
  import pic_pkg::*;
#(
  parameter int N_LINES = PIC_LINES,
  localparam int IDW = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               slave_mode,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic               bus_a0,
  input  logic [N_LINES-1:0] bus_wdata,
  output logic [N_LINES-1:0] bus_rdata,
  input  logic [N_LINES-1:0] irq_in,
  output logic               int_req,
  input  logic               int_ack,
  input  logic [IDW-1:0]     cas_in,
  output logic [IDW-1:0]     cas_out,
  output logic               cas_drive,
  output logic [7:0]         vec_out,
  output logic               vec_valid
);
  logic [N_LINES-1:0] mask, irr, isr;
  pic_cfg_t           cfg;
  logic               init_stb, eoi_stb;
  logic [IDW-1:0]     eoi_idx;

  pic_cfg_regs #(.W(N_LINES)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_a0   (bus_a0),
    .bus_wdata(bus_wdata),
    .irr      (irr),
    .isr      (isr),
    .mask     (mask),
    .cfg      (cfg),
    .rdata    (bus_rdata),
    .init_stb (init_stb),
    .eoi_stb  (eoi_stb),
    .eoi_idx  (eoi_idx)
  );

  pic_req_core #(.N(N_LINES)) u_core (
    .clk       (clk),
    .rst       (rst),
    .slave_mode(slave_mode),
    .irq_in    (irq_in),
    .mask      (mask),
    .cfg       (cfg),
    .init_stb  (init_stb),
    .eoi_stb   (eoi_stb),
    .eoi_idx   (eoi_idx),
    .int_ack   (int_ack),
    .cas_in    (cas_in),
    .irr_q     (irr),
    .isr_q     (isr),
    .int_req   (int_req),
    .vec_out   (vec_out),
    .vec_valid (vec_valid),
    .cas_out   (cas_out),
    .cas_drive (cas_drive)
  );

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    rst |=> (!int_req && !vec_valid && !cas_drive));
endmodule

// File: tb/test_pic8_ctrl.sv
module test_pic8_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       slave_mode = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_a0 = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] irq_in = '0;
  logic       int_req;
  logic       int_ack = 1'b0;
  logic [2:0] cas_in = '0;
  logic [2:0] cas_out;
  logic       cas_drive;
  logic [7:0] vec_out;
  logic       vec_valid;

  int n_chk = 0;
  int n_fail = 0;
  bit started = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pic8_ctrl i_pic8_ctrl (
    .clk(clk), .rst(rst), .slave_mode(slave_mode),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_a0(bus_a0),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .int_req(int_req), .int_ack(int_ack),
    .cas_in(cas_in), .cas_out(cas_out), .cas_drive(cas_drive),
    .vec_out(vec_out), .vec_valid(vec_valid)
  );

  // Behavioural reference model
  bit [7:0] m_irr, m_isr, m_mask, m_prev, m_map;
  int       m_st, m_sel;
  bit       m_n3, m_n4, m_aeoi, m_rdisr, m_ph, m_spur, m_casc;
  bit [4:0] m_base;
  bit       e_int, e_vv, e_oe;
  bit [7:0] e_vec, e_rd;
  bit [2:0] e_cas;

  always @(posedge clk) begin
    int top, hi;
    bit elig, me;
    bit [7:0] nirr, nisr;
    if (rst) begin
      m_irr = 0; m_isr = 0; m_mask = 8'hFF; m_prev = 0; m_map = 0;
      m_st = 0; m_sel = 0; m_n3 = 0; m_n4 = 0; m_aeoi = 0; m_rdisr = 0;
      m_ph = 0; m_spur = 0; m_casc = 0; m_base = 0;
      e_int = 0; e_vv = 0; e_oe = 0; e_vec = 0; e_rd = 0; e_cas = 0;
    end else begin
      top = -1; hi = -1;
      for (int i = 0; i < 8; i++) if (top < 0 && m_irr[i] && !m_mask[i]) top = i;
      for (int i = 0; i < 8; i++) if (hi < 0 && m_isr[i]) hi = i;
      elig = (top >= 0) && (hi < 0 || top < hi);
      if (bus_rd) e_rd = bus_a0 ? m_mask : (m_rdisr ? m_isr : m_irr);
      e_vv = 0;
      nirr = m_irr; nisr = m_isr;
      for (int i = 0; i < 8; i++) begin
        if (irq_in[i] && !m_prev[i]) nirr[i] = 1;
        if (!irq_in[i]) nirr[i] = 0;
      end
      m_prev = irq_in;
      me = int_ack && (!slave_mode || cas_in == m_map[2:0]);
      if (bus_wr && !bus_a0 && bus_wdata[4]) begin
        nirr = 0; nisr = 0; m_ph = 0; e_oe = 0; e_cas = 0;
        m_st = 1; m_n3 = !bus_wdata[1]; m_n4 = bus_wdata[0];
        m_aeoi = 0; m_rdisr = 0; m_map = 0;
      end else begin
        if (me && !m_ph) begin
          m_ph = 1;
          if (elig) begin
            nirr[top] = 0; nisr[top] = 1; m_sel = top; m_spur = 0;
            m_casc = !slave_mode && m_map[top];
          end else begin
            m_sel = 7; m_spur = 1; m_casc = 0;
          end
          e_oe = m_casc;
          e_cas = m_casc ? 3'(m_sel) : 3'd0;
        end else if (me && m_ph) begin
          m_ph = 0;
          e_vv = !m_casc;
          e_vec = {m_base, 3'(m_sel)};
          if (m_aeoi && !m_spur) nisr[m_sel] = 0;
          e_oe = 0; e_cas = 0;
        end
        if (bus_wr && !bus_a0 && !bus_wdata[3] && bus_wdata[7:5] == 3'b011)
          nisr[bus_wdata[2:0]] = 0;
        if (bus_wr && !bus_a0 && bus_wdata[3] && bus_wdata[1]) m_rdisr = bus_wdata[0];
        if (bus_wr && bus_a0) begin
          case (m_st)
            1: begin m_base = bus_wdata[7:3]; m_st = m_n3 ? 2 : (m_n4 ? 3 : 0); end
            2: begin m_map = bus_wdata; m_st = m_n4 ? 3 : 0; end
            3: begin m_aeoi = bus_wdata[1]; m_st = 0; end
            default: m_mask = bus_wdata;
          endcase
        end
      end
      m_irr = nirr; m_isr = nisr; e_int = elig;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Per-clock comparison against the model (R5 R6 R11)
  always @(negedge clk) begin
    if (started && !rst && !done) begin
      chk(int_req == e_int, "R5 int_req vs model", {7'd0, int_req}, {7'd0, e_int});
      chk(vec_valid == e_vv, "R6 vec_valid vs model", {7'd0, vec_valid}, {7'd0, e_vv});
      if (vec_valid && e_vv) chk(vec_out == e_vec, "R6 vec_out vs model", vec_out, e_vec);
      chk(cas_drive == e_oe && cas_out == e_cas, "R11 cascade vs model",
          {4'd0, cas_drive, cas_out}, {4'd0, e_oe, e_cas});
    end
  end

  task automatic wr(input bit a0, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_a0 = a0; bus_wdata = d;
    @(negedge clk); bus_wr = 0; bus_a0 = 0; bus_wdata = 0;
  endtask

  task automatic rd(input bit a0, input logic [7:0] exp, input string tag);
    @(negedge clk); bus_rd = 1; bus_a0 = a0;
    @(negedge clk); bus_rd = 0; bus_a0 = 0;
    chk(bus_rdata == exp, tag, bus_rdata, exp);
    chk(bus_rdata == e_rd, {tag, " model"}, bus_rdata, e_rd);
  endtask

  task automatic pulse();
    @(negedge clk); int_ack = 1;
    @(negedge clk); int_ack = 0;
  endtask

  task automatic ack_seq(input bit exp_v, input logic [7:0] exp_vec, input string tag);
    pulse();
    pulse();
    chk(vec_valid == exp_v, {tag, " valid"}, {7'd0, vec_valid}, {7'd0, exp_v});
    if (exp_v) chk(vec_out == exp_vec, {tag, " vector"}, vec_out, exp_vec);
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic chk_int(input bit exp, input string tag);
    chk(int_req == exp, tag, {7'd0, int_req}, {7'd0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    started = 1;
    @(negedge clk);
    // R1 reset state
    chk(!int_req && !vec_valid && !cas_drive, "R1 outputs idle", {5'd0, int_req, vec_valid, cas_drive}, 8'h00);
    rd(1, 8'hFF, "R1 mask after reset");
    rd(0, 8'h00, "R1 pending after reset");

    // R2 master programming, normal EOI
    wr(0, 8'h11); wr(1, 8'h20); wr(1, 8'h04); wr(1, 8'h01);
    wr(1, 8'h00);
    rd(1, 8'h00, "R3 mask readback");

    // R5 R6 basic request
    irq_in[3] = 1; idle(3);
    chk_int(1, "R5 line 3 raises int_req");
    ack_seq(1, 8'h23, "R6 line 3");
    wr(0, 8'h0B);
    rd(0, 8'h08, "R10 in-service select");
    irq_in[5] = 1; idle(3);
    chk_int(0, "R5 lower line blocked by service");
    irq_in[1] = 1; idle(3);
    chk_int(1, "R5 higher line nests");
    ack_seq(1, 8'h21, "R6 line 1");
    rd(0, 8'h0A, "R6 nested in-service");
    wr(0, 8'h61);
    rd(0, 8'h08, "R8 eoi line 1 only");
    wr(0, 8'h63);
    rd(0, 8'h00, "R8 eoi line 3");
    idle(2);
    chk_int(1, "R5 line 5 released");
    ack_seq(1, 8'h25, "R6 line 5");
    wr(0, 8'h65);
    irq_in = 0;

    // R4 R7 request vanishes
    irq_in[4] = 1; idle(3);
    chk_int(1, "R4 line 4 pending");
    irq_in[4] = 0; idle(3);
    chk_int(0, "R4 drop removes request");
    wr(0, 8'h0A);
    rd(0, 8'h00, "R4 pending cleared on drop");
    ack_seq(1, 8'h27, "R7 spurious vector");
    wr(0, 8'h0B);
    rd(0, 8'h00, "R7 no in-service bit");
    wr(1, 8'h80);
    ack_seq(1, 8'h27, "R7 spurious with line 7 masked");

    // R3 masking
    wr(1, 8'h40);
    irq_in[6] = 1; idle(3);
    chk_int(0, "R3 masked line silent");
    wr(0, 8'h0A);
    rd(0, 8'h40, "R10 pending select shows masked line");
    wr(1, 8'h00); idle(3);
    chk_int(1, "R3 unmask forwards");
    ack_seq(1, 8'h26, "R6 line 6");
    rd(0, 8'h00, "R4 acknowledge clears pending");
    wr(0, 8'h66);
    irq_in[6] = 0;

    // R11 cascade line on master
    irq_in[2] = 1; idle(3);
    pulse();
    chk(cas_drive && cas_out == 3'd2, "R11 cascade drive", {4'd0, cas_drive, cas_out}, 8'h0A);
    pulse();
    chk(!vec_valid && !cas_drive, "R11 master gives no vector", {6'd0, vec_valid, cas_drive}, 8'h00);
    wr(0, 8'h62);
    irq_in[2] = 0;

    // Same cycle: acknowledge of line 1 with eoi of line 3
    irq_in[3] = 1; idle(3);
    ack_seq(1, 8'h23, "R6 line 3 again");
    irq_in[1] = 1; idle(3);
    @(negedge clk); int_ack = 1; bus_wr = 1; bus_a0 = 0; bus_wdata = 8'h63;
    @(negedge clk); int_ack = 0; bus_wr = 0; bus_wdata = 0;
    pulse();
    chk(vec_valid && vec_out == 8'h21, "R8 ack with concurrent eoi", vec_out, 8'h21);
    wr(0, 8'h0B);
    rd(0, 8'h02, "R8 only new line in service");
    wr(0, 8'h61);
    irq_in = 0;

    // R2 restart clears service; R9 auto EOI
    irq_in[0] = 1; idle(3);
    ack_seq(1, 8'h20, "R6 line 0");
    irq_in[0] = 0;
    wr(0, 8'h11); wr(1, 8'h20); wr(1, 8'h04); wr(1, 8'h03);
    wr(0, 8'h0B);
    rd(0, 8'h00, "R2 restart cleared in-service");
    rd(1, 8'h00, "R2 mask kept across restart");
    irq_in[3] = 1; idle(3);
    ack_seq(1, 8'h23, "R9 auto mode vector");
    rd(0, 8'h00, "R9 auto release");
    irq_in[3] = 0;

    // R2 single mode, word 4 present: word 3 skipped
    wr(0, 8'h13); wr(1, 8'h40); wr(1, 8'h01); wr(1, 8'h00);
    irq_in[0] = 1; idle(3);
    ack_seq(1, 8'h40, "R2 single-mode base");
    wr(0, 8'h60);
    irq_in[0] = 0;
    // R2 single mode, no word 4
    wr(0, 8'h12); wr(1, 8'h50); wr(1, 8'hFE);
    rd(1, 8'hFE, "R2 short sequence then mask");
    wr(1, 8'h00);

    // R12 slave
    @(negedge clk); slave_mode = 1;
    wr(0, 8'h11); wr(1, 8'h28); wr(1, 8'h02); wr(1, 8'h01); wr(1, 8'h00);
    irq_in[4] = 1; idle(3);
    chk_int(1, "R12 slave request");
    cas_in = 3'd3;
    ack_seq(0, 8'h00, "R12 foreign identity ignored");
    wr(0, 8'h0B);
    rd(0, 8'h00, "R12 no service on foreign ack");
    cas_in = 3'd2;
    ack_seq(1, 8'h2C, "R12 own identity");
    rd(0, 8'h10, "R12 slave in service");
    irq_in = 0;
    idle(3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule